// File: doc/BRIEF.md
# Pixel Brightness, Contrast, Saturation and Hue Adjuster

This block corrects one YCbCr pixel per clock before the pixel reaches a colour-space converter. The luma sample is scaled by a contrast gain and then offset by a brightness value. The chroma pair is scaled and rotated by a cosine/sine pair that encodes saturation and hue. All three results are rounded, saturated to their legal ranges and registered. A common use is stretching limited-range video (luma 16..235, chroma ±112) out to full range: contrast 75, brightness -19 and cosine 146 with sine 0.

Software writes two 32-bit parameter words at any time. Each write lands in a staging copy. The datapath works only from an active copy. The active copy takes the staging contents on every clock edge at which the vertical-blanking input is high, so a frame is never processed with a mix of old and new settings.

Top module: `pix_color_adjust`

## Requirements
- R1: While reset is high and on the first sample after it, out_valid, out_y, out_cb and out_cr are 0. Both the staging and the active parameters reset to pass-through: contrast 64, brightness 0, cosine 128, sine 0.
- R2: A pixel presented with in_valid high appears exactly 2 clock edges later with out_valid high. A cycle with in_valid low gives out_valid low 2 edges later. A new pixel is accepted on every cycle.
- R3: Luma out_y = clamp(floor((Y*C + 32)/64) + B, 0, 255). C is the unsigned contrast in word-0 bits 26:18 (6 fractional bits). B is the two's-complement brightness in word-0 bits 7:0. Contrast is applied before brightness.
- R4: Chroma out_cb = floor((K*Cb + S*Cr + 64)/128) and out_cr = floor((K*Cr - S*Cb + 64)/128). K is the unsigned cosine in word-1 bits 9:0 (7 fractional bits). S is the two's-complement sine in word-1 bits 26:16. Cb and Cr are two's complement on both ports.
- R5: Results saturate rather than wrap: luma to 0..255 and each chroma output to -128..127.
- R6: A parameter write changes nothing at the outputs until a later clock edge at which vblank is high. That edge copies the staging words as they stood before it. A write in that same cycle is held for the next vblank edge. Bits of either word outside the named fields have no effect.
- R7: With pass-through parameters, every output sample equals its input sample.
- R8: With the limited-range settings (contrast 75, brightness -19, cosine 146, sine 0), luma 16 maps to 0 and luma 235 to 255, and chroma +112 saturates to 127 while -112 maps to -128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg0_wr | input | 1 | Write strobe for parameter word 0 (contrast, brightness) |
| cfg0_data | input | 32 | Parameter word 0 |
| cfg1_wr | input | 1 | Write strobe for parameter word 1 (sine, cosine) |
| cfg1_data | input | 32 | Parameter word 1 |
| vblank | input | 1 | Vertical blanking; staging parameters become active on edges where it is high |
| in_valid | input | 1 | Input pixel valid |
| in_y | input | 8 | Input luma, unsigned |
| in_cb | input | 8 | Input blue-difference chroma, two's complement |
| in_cr | input | 8 | Input red-difference chroma, two's complement |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Corrected luma |
| out_cb | output | 8 | Corrected blue-difference chroma, two's complement |
| out_cr | output | 8 | Corrected red-difference chroma, two's complement |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a 9-bit contrast, an 11-bit sine and a 10-bit cosine. These widths make the extreme corners reachable with random words. A contrast near 8.0 combined with a large brightness drives luma past both rails. Sine and cosine near their limits push the chroma sums past ±128. The bench also exercises a negative sine at -1024. Random vblank timing against random parameter writes covers writes held in staging and writes that coincide with a vblank edge.

// File: rtl/pca_pkg.sv
package pca_pkg;
  // parameter word 0
  localparam int CON_LSB   = 18;
  localparam int CON_W     = 9;
  localparam int CON_FRAC  = 6;
  localparam int BRI_LSB   = 0;
  localparam int BRI_W     = 8;
  // parameter word 1
  localparam int SIN_LSB   = 16;
  localparam int SIN_W     = 11;
  localparam int COS_LSB   = 0;
  localparam int COS_W     = 10;
  localparam int TRIG_FRAC = 7;

  typedef struct packed {
    logic [CON_W-1:0]        contrast;
    logic signed [BRI_W-1:0] bright;
    logic signed [SIN_W-1:0] sin_t;
    logic [COS_W-1:0]        cos_t;
  } adj_cfg_t;

  localparam adj_cfg_t CFG_IDENT = '{
    contrast: CON_W'(1 << CON_FRAC),
    bright:   '0,
    sin_t:    '0,
    cos_t:    COS_W'(1 << TRIG_FRAC)
  };
endpackage

// File: rtl/pca_cfg_shadow.sv
module pca_cfg_shadow
  import pca_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr0,
  input  logic [REG_W-1:0] d0,
  input  logic             wr1,
  input  logic [REG_W-1:0] d1,
  input  logic             vblank,
  output adj_cfg_t         active
);
  adj_cfg_t stg_q, act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= CFG_IDENT;
      act_q <= CFG_IDENT;
    end else begin
      if (wr0) begin
        stg_q.contrast <= d0[CON_LSB +: CON_W];
        stg_q.bright   <= d0[BRI_LSB +: BRI_W];
      end
      if (wr1) begin
        stg_q.sin_t <= d1[SIN_LSB +: SIN_W];
        stg_q.cos_t <= d1[COS_LSB +: COS_W];
      end
      if (vblank) act_q <= stg_q;
    end
  end

  assign active = act_q;

  // R6: active copy only moves on a vblank edge
  p_hold_outside_blank_r6: assert property (@(posedge clk) disable iff (rst)
    !vblank |=> $stable(act_q));
  // R6: vblank edge takes the staging copy as it was before the edge
  p_load_on_blank_r6: assert property (@(posedge clk) disable iff (rst)
    vblank |=> (act_q == $past(stg_q)));
endmodule

// File: rtl/pca_luma_path.sv
module pca_luma_path
  import pca_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DW-1:0]           y_i,
  input  logic [CON_W-1:0]        contrast_i,
  input  logic signed [BRI_W-1:0] bright_i,
  output logic [DW-1:0]           y_o
);
  localparam int PW   = DW + CON_W;
  localparam int SW   = PW + 2;
  localparam int HALF = 1 << (CON_FRAC - 1);
  localparam int YMAX = (1 << DW) - 1;

  logic [PW-1:0]           prod_q;
  logic signed [BRI_W-1:0] bri_q;
  logic [PW:0]             rnd;
  logic signed [SW-1:0]    sum;
  logic [DW-1:0]           y_sat;

  // stage 1: contrast gain
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      bri_q  <= '0;
    end else begin
      prod_q <= PW'(y_i) * PW'(contrast_i);
      bri_q  <= bright_i;
    end
  end

  // stage 2: round, brightness, saturate
  always_comb begin
    rnd = ({1'b0, prod_q} + (PW+1)'(HALF)) >> CON_FRAC;
    sum = signed'({1'b0, rnd}) + SW'(bri_q);
    if (sum[SW-1])                 y_sat = '0;
    else if (sum > SW'(YMAX))      y_sat = DW'(YMAX);
    else                           y_sat = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) y_o <= '0;
    else     y_o <= y_sat;
  end
endmodule

// File: rtl/pca_chroma_lane.sv
module pca_chroma_lane
  import pca_pkg::*;
#(
  parameter int DW  = 8,
  parameter bit NEG = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [DW-1:0]    a_i,
  input  logic signed [DW-1:0]    b_i,
  input  logic [COS_W-1:0]        cos_i,
  input  logic signed [SIN_W-1:0] sin_i,
  output logic signed [DW-1:0]    o_q
);
  localparam int KW   = (SIN_W > COS_W + 1) ? SIN_W : COS_W + 1;
  localparam int PW   = DW + KW;
  localparam int SW   = PW + 1;
  localparam int HALF = 1 << (TRIG_FRAC - 1);
  localparam int OMAX = (1 << (DW - 1)) - 1;
  localparam int OMIN = -(1 << (DW - 1));

  logic signed [PW-1:0] a_x, b_x, c_x, s_x, pa, pb;
  logic signed [PW-1:0] pa_q, pb_q;
  logic signed [SW-1:0] sum, sh;
  logic signed [DW-1:0] sat;

  always_comb begin
    a_x = PW'(a_i);
    b_x = PW'(b_i);
    c_x = signed'(PW'(cos_i));
    s_x = PW'(sin_i);
    pa  = c_x * a_x;
  end

  generate
    if (NEG) begin : g_sub
      assign pb = -(s_x * b_x);
    end else begin : g_add
      assign pb = s_x * b_x;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q <= '0;
      pb_q <= '0;
    end else begin
      pa_q <= pa;
      pb_q <= pb;
    end
  end

  always_comb begin
    sum = SW'(pa_q) + SW'(pb_q) + SW'(HALF);
    sh  = sum >>> TRIG_FRAC;
    if (sh > SW'(OMAX))      sat = DW'(OMAX);
    else if (sh < SW'(OMIN)) sat = DW'(OMIN);
    else                     sat = sh[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) o_q <= '0;
    else     o_q <= sat;
  end
endmodule

// File: rtl/pix_color_adjust.sv
module pix_color_adjust
  import pca_pkg::*;
#(
  parameter int DW    = 8,
  parameter int REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg0_wr,
  input  logic [REG_W-1:0]     cfg0_data,
  input  logic                 cfg1_wr,
  input  logic [REG_W-1:0]     cfg1_data,
  input  logic                 vblank,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_y,
  input  logic signed [DW-1:0] in_cb,
  input  logic signed [DW-1:0] in_cr,
  output logic                 out_valid,
  output logic [DW-1:0]        out_y,
  output logic signed [DW-1:0] out_cb,
  output logic signed [DW-1:0] out_cr
);
  localparam int LAT = 2;

  adj_cfg_t       act;
  logic [LAT-1:0] vld_q;

  pca_cfg_shadow #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst),
    .wr0(cfg0_wr), .d0(cfg0_data),
    .wr1(cfg1_wr), .d1(cfg1_data),
    .vblank(vblank), .active(act)
  );

  pca_luma_path #(.DW(DW)) u_luma (
    .clk(clk), .rst(rst), .y_i(in_y),
    .contrast_i(act.contrast), .bright_i(act.bright), .y_o(out_y)
  );

  pca_chroma_lane #(.DW(DW), .NEG(1'b0)) u_cb (
    .clk(clk), .rst(rst), .a_i(in_cb), .b_i(in_cr),
    .cos_i(act.cos_t), .sin_i(act.sin_t), .o_q(out_cb)
  );

  pca_chroma_lane #(.DW(DW), .NEG(1'b1)) u_cr (
    .clk(clk), .rst(rst), .a_i(in_cr), .b_i(in_cb),
    .cos_i(act.cos_t), .sin_i(act.sin_t), .o_q(out_cr)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[LAT-2:0], in_valid};
  end
  assign out_valid = vld_q[LAT-1];

  logic ident;
  assign ident = (act == CFG_IDENT);

  // R2: valid follows the data two edges later
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  p_bubble_latency_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  // R7: identity settings leave the samples untouched
  p_ident_luma_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ident) |-> ##2 (out_y == $past(in_y, 2)));
  p_ident_chroma_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ident) |-> ##2 (out_cb == $past(in_cb, 2) && out_cr == $past(in_cr, 2)));
endmodule

// File: tb/pix_color_adjust_tb.sv
module pix_color_adjust_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg0_wr = 1'b0, cfg1_wr = 1'b0, vblank = 1'b0, in_valid = 1'b0;
  logic [31:0] cfg0_data = '0, cfg1_data = '0;
  logic [7:0] in_y = '0;
  logic signed [7:0] in_cb = '0, in_cr = '0;
  logic out_valid;
  logic [7:0] out_y;
  logic signed [7:0] out_cb, out_cr;

  always #10 clk = ~clk; // 50 MHz

  pix_color_adjust u_dut (
    .clk(clk), .rst(rst),
    .cfg0_wr(cfg0_wr), .cfg0_data(cfg0_data),
    .cfg1_wr(cfg1_wr), .cfg1_data(cfg1_data),
    .vblank(vblank), .in_valid(in_valid),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  typedef struct {
    bit    v;
    int    y;
    int    cb;
    int    cr;
    string tag;
  } exp_t;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t eq0, eq1;
  // model: staged and active parameters
  int s_con = 64, s_bri = 0, s_sin = 0, s_cos = 128;
  int a_con = 64, a_bri = 0, a_sin = 0, a_cos = 128;

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int f_y(int y, int c, int b);
    return clampi(((y * c + 32) >>> 6) + b, 0, 255);
  endfunction

  function automatic int f_ch(int a, int b, int k, int s, bit neg);
    int t;
    t = k * a + (neg ? -(s * b) : s * b) + 64;
    return clampi(t >>> 7, -128, 127);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic check_out();
    checks++;
    if (out_valid !== eq1.v) begin
      fails++;
      $display("FAIL %s valid: got %0b expected %0b", eq1.tag, out_valid, eq1.v);
    end else if (eq1.v && (int'(out_y) != eq1.y || int'(out_cb) != eq1.cb ||
                           int'(out_cr) != eq1.cr)) begin
      fails++;
      $display("FAIL %s pixel: got y=%0d cb=%0d cr=%0d expected y=%0d cb=%0d cr=%0d",
               eq1.tag, out_y, out_cb, out_cr, eq1.y, eq1.cb, eq1.cr);
    end
  endtask

  // one cycle: check, drive, predict, update model, advance
  task automatic cyc(bit v, int y, int cb, int cr, bit vb,
                     bit w0, logic [31:0] d0, bit w1, logic [31:0] d1, string tag);
    exp_t e;
    check_out();
    in_valid = v; in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
    vblank = vb; cfg0_wr = w0; cfg0_data = d0; cfg1_wr = w1; cfg1_data = d1;
    e.v = v; e.tag = tag;
    e.y  = f_y(y, a_con, a_bri);
    e.cb = f_ch(cb, cr, a_cos, a_sin, 1'b0);
    e.cr = f_ch(cr, cb, a_cos, a_sin, 1'b1);
    if (vb) begin
      a_con = s_con; a_bri = s_bri; a_sin = s_sin; a_cos = s_cos;
    end
    if (w0) begin
      s_con = int'(d0[26:18]);
      s_bri = int'($signed(d0[7:0]));
    end
    if (w1) begin
      s_sin = int'($signed(d1[26:16]));
      s_cos = int'(d1[9:0]);
    end
    eq1 = eq0; eq0 = e;
    @(negedge clk);
  endtask

  task automatic pix(int y, int cb, int cr, string tag);
    cyc(1'b1, y, cb, cr, 1'b0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  function automatic int rs8();
    return int'($signed(8'($urandom_range(0, 255))));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  localparam logic [31:0] LIM0 = 32'hF803_FF00 | (32'd75 << 18) | 32'h0000_00ED;
  localparam logic [31:0] LIM1 = 32'hF800_FC00 | 32'd146;
  localparam logic [31:0] IDW0 = 32'd64 << 18;
  localparam logic [31:0] IDW1 = 32'd128;

  initial begin
    int ys[5];
    int cs[5];
    void'($urandom(32'd20240611));
    ys = '{16, 235, 128, 0, 255};
    cs = '{112, -112, 0, 127, -128};
    eq0 = '{0, 0, 0, 0, "R1"}; eq1 = eq0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_y !== 8'd0 || out_cb !== 8'sd0 || out_cr !== 8'sd0) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b y=%0d cb=%0d cr=%0d expected all 0",
               out_valid, out_y, out_cb, out_cr);
    end
    // R7 / R2: pass-through after reset, with bubbles
    for (int i = 0; i < 60; i++)
      cyc(($urandom_range(0, 3) != 0), $urandom_range(0, 255), rs8(), rs8(),
          1'b0, 1'b0, '0, 1'b0, '0, "R7 R2");
    // R6: limited-range words written (with junk bits) but not yet active
    cyc(1'b1, 200, 100, -100, 1'b0, 1'b1, LIM0, 1'b1, LIM1, "R6");
    for (int i = 0; i < 10; i++)
      pix($urandom_range(0, 255), rs8(), rs8(), "R6");
    cyc(1'b0, 0, 0, 0, 1'b1, 1'b0, '0, 1'b0, '0, "R6");
    // R8 / R5: limited to full range corners
    foreach (ys[i]) foreach (cs[j]) pix(ys[i], cs[j], cs[4 - j], "R8 R5");
    // R3 R4 R5 R6: random parameters, random blanking
    for (int i = 0; i < 4000; i++)
      cyc(($urandom_range(0, 3) != 0), $urandom_range(0, 255), rs8(), rs8(),
          ($urandom_range(0, 15) == 0),
          ($urandom_range(0, 7) == 0), $urandom,
          ($urandom_range(0, 7) == 0), $urandom, "R3 R4 R5 R6");
    // R4 R5: extreme negative sine and full cosine
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, 32'd511 << 18 | 32'h7F, 1'b1,
        (32'h400 << 16) | 32'h3FF, "R4 R5");
    cyc(1'b0, 0, 0, 0, 1'b1, 1'b0, '0, 1'b0, '0, "R4 R5");
    foreach (cs[i]) foreach (cs[j]) pix(ys[i], cs[i], cs[j], "R4 R5");
    // R6: write coinciding with vblank waits for the next vblank
    cyc(1'b1, 50, 20, -30, 1'b1, 1'b1, IDW0, 1'b1, IDW1, "R6");
    for (int i = 0; i < 8; i++) pix($urandom_range(0, 255), rs8(), rs8(), "R6");
    cyc(1'b0, 0, 0, 0, 1'b1, 1'b0, '0, 1'b0, '0, "R6");
    for (int i = 0; i < 20; i++) pix($urandom_range(0, 255), rs8(), rs8(), "R7 R6");
    repeat (3) cyc(1'b0, 0, 0, 0, 1'b0, 1'b0, '0, 1'b0, '0, "R2");
    done = 1;
    summary();
    $finish;
  end
endmodule